// File: doc/BRIEF.md
# Lasso Monitor for Liveness-as-Safety Checking

This block sits beside a design under formal analysis and watches its state vector. A free `save` input stands for a nondeterministic choice by the model checker. When `save` is high, the monitor copies the current state into a shadow register and arms itself. From then on, each liveness signal and each fairness signal has its own sticky "seen" latch. A lasso is closed when the live state equals the stored copy. The single `violation` output rises on a closed lasso along which every fairness signal has appeared but at least one liveness signal has not. That makes the output a safety target: a trace that reaches `violation == 1` is a counterexample to the liveness property.

A second build variant handles loops of length one only. It keeps no registers at all. It compares the current state with the design's next state in the same cycle that `save` is high, and it uses the liveness and fairness signals as sampled in that cycle. A generate choice on the `ONE_STEP` parameter picks the variant. Empty liveness or fairness sets are legal, and each counts as all satisfied.

Top module: `lasso_monitor`

## Requirements
- R1: In the general variant, a cycle with `save` high sets the armed flag at the next clock edge. The flag then stays set until reset.
- R2: The shadow copy takes `state_cur` at each edge where `save` is high. At every other edge it keeps its value.
- R3: The loop condition is true only while the armed flag is set and every bit of `state_cur` equals the shadow copy. It is evaluated in the same cycle, with no added register.
- R4: Each liveness or fairness lane has a seen latch. Its next value is `(save ? 0 : seen) | (sig & (save | armed))`. A new snapshot therefore restarts every latch from that cycle's sample. Before the first snapshot, every latch stays 0.
- R5: `violation` = loop AND (every fairness latch set) AND NOT (every liveness latch set). It is combinational from the registers and `state_cur`.
- R6: With `N_LIVE = 0` the liveness term counts as all set, so `violation` stays 0. With `N_FAIR = 0` the fairness term counts as all set. Unused signal lanes are ignored.
- R7: A synchronous active-high `rst` clears the armed flag, the shadow copy and all seen latches at the clock edge where it is high.
- R8: With `ONE_STEP = 1`, `violation` = `save` AND (`state_cur == state_nxt`) AND (all of `fair_sig`) AND NOT (all of `live_sig`). No state is kept.
- R9: A `save` while already armed starts a new snapshot. The shadow copy is replaced and every seen latch restarts, so signals seen before the new snapshot no longer count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save | input | 1 | Free snapshot choice |
| state_cur | input | STATE_W | Current state vector of the observed design |
| state_nxt | input | STATE_W | Next state vector (used only by the one-step variant) |
| live_sig | input | max(N_LIVE,1) | Liveness signals, one per lane |
| fair_sig | input | max(N_FAIR,1) | Fairness signals, one per lane |
| violation | output | 1 | Lasso found that breaks liveness under fairness |

## Verification
The assertions check the following on every cycle:
- the stickiness of the armed flag;
- loading and holding of the shadow copy;
- the restart of the seen latches on `save`;
- that a violation never appears without a loop and full fairness;
- the clearing effect of reset.

Only the bench scenarios can show the full output value. These include a loop that closes, opens and closes again, a liveness lane arriving one lane at a time, a re-snapshot that discards earlier history, and the empty-set variants. The bench compares against a lasso model in which the same inputs drive four builds at once.

// File: rtl/lasso_pkg.sv
package lasso_pkg;

  // Width of a lane vector: a zero-lane set still gets one (ignored) bit.
  function automatic int lanes(input int n);
    return (n > 0) ? n : 1;
  endfunction

  // Next value of one seen latch: a snapshot drops history, an armed
  // monitor records a high sample.
  function automatic logic seen_next(input logic held, input logic snap,
                                     input logic sig, input logic armed);
    return (snap ? 1'b0 : held) | (sig & armed);
  endfunction

  // Final verdict: lasso closed, fairness met, liveness not met.
  function automatic logic verdict(input logic loop, input logic fair_ok,
                                   input logic live_ok);
    return loop & fair_ok & ~live_ok;
  endfunction

endpackage

// File: rtl/lasso_match.sv
module lasso_match #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  // AND chain over per-bit XNORs.
  logic [W-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_first
        assign chain[i] = ~(a[i] ^ b[i]);
      end else begin : g_next
        assign chain[i] = chain[i-1] & ~(a[i] ^ b[i]);
      end
    end
  endgenerate

  assign eq = chain[W-1];
endmodule

// File: rtl/lasso_snapshot.sv
module lasso_snapshot #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         save,
  input  logic [W-1:0] state_cur,
  output logic         saved_q,
  output logic [W-1:0] shadow_q,
  output logic         armed,
  output logic         loop_hit
);
  logic match;

  always_ff @(posedge clk) begin
    if (rst) begin
      saved_q  <= 1'b0;
      shadow_q <= '0;
    end else begin
      saved_q <= save | saved_q;
      if (save) shadow_q <= state_cur;
    end
  end

  lasso_match #(.W(W)) u_match (
    .a  (state_cur),
    .b  (shadow_q),
    .eq (match)
  );

  assign armed    = save | saved_q;
  assign loop_hit = saved_q & match;
endmodule

// File: rtl/lasso_seen_bank.sv
module lasso_seen_bank
  import lasso_pkg::*;
#(
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                save,
  input  logic                armed,
  input  logic [lanes(N)-1:0] sig,
  output logic [lanes(N)-1:0] seen_q,
  output logic                all_seen
);
  generate
    if (N == 0) begin : g_empty
      logic unused_lane;
      assign unused_lane = ^{sig, clk, rst, save, armed};
      assign seen_q      = '0;
      assign all_seen    = 1'b1;
    end else begin : g_lanes
      genvar k;
      for (k = 0; k < N; k++) begin : g_lane
        always_ff @(posedge clk) begin
          if (rst) seen_q[k] <= 1'b0;
          else     seen_q[k] <= seen_next(seen_q[k], save, sig[k], armed);
        end
      end
      assign all_seen = &seen_q;
    end
  endgenerate
endmodule

// File: rtl/lasso_monitor.sv
module lasso_monitor
  import lasso_pkg::*;
#(
  parameter int STATE_W  = 4,
  parameter int N_LIVE   = 2,
  parameter int N_FAIR   = 2,
  parameter bit ONE_STEP = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     save,
  input  logic [STATE_W-1:0]       state_cur,
  input  logic [STATE_W-1:0]       state_nxt,
  input  logic [lanes(N_LIVE)-1:0] live_sig,
  input  logic [lanes(N_FAIR)-1:0] fair_sig,
  output logic                     violation
);
  localparam int LW = lanes(N_LIVE);
  localparam int FW = lanes(N_FAIR);

  // Named internal events, observed by the bound checker.
  logic               saved_q;
  logic [STATE_W-1:0] shadow_q;
  logic               armed;
  logic               loop_hit;
  logic [LW-1:0]      live_seen;
  logic [FW-1:0]      fair_seen;
  logic               live_all;
  logic               fair_all;

  generate
    if (ONE_STEP) begin : g_one_step
      logic step_eq;
      logic unused_os;
      lasso_match #(.W(STATE_W)) u_step_match (
        .a  (state_cur),
        .b  (state_nxt),
        .eq (step_eq)
      );
      assign unused_os = clk ^ rst;
      assign saved_q   = 1'b0;
      assign shadow_q  = '0;
      assign armed     = save;
      assign loop_hit  = save & step_eq;
      assign live_seen = '0;
      assign fair_seen = '0;
      assign live_all  = (N_LIVE == 0) ? 1'b1 : &live_sig[LW-1:0];
      assign fair_all  = (N_FAIR == 0) ? 1'b1 : &fair_sig[FW-1:0];
    end else begin : g_general
      logic unused_nxt;
      assign unused_nxt = ^state_nxt;

      lasso_snapshot #(.W(STATE_W)) u_snap (
        .clk       (clk),
        .rst       (rst),
        .save      (save),
        .state_cur (state_cur),
        .saved_q   (saved_q),
        .shadow_q  (shadow_q),
        .armed     (armed),
        .loop_hit  (loop_hit)
      );

      lasso_seen_bank #(.N(N_LIVE)) u_live (
        .clk      (clk),
        .rst      (rst),
        .save     (save),
        .armed    (armed),
        .sig      (live_sig),
        .seen_q   (live_seen),
        .all_seen (live_all)
      );

      lasso_seen_bank #(.N(N_FAIR)) u_fair (
        .clk      (clk),
        .rst      (rst),
        .save     (save),
        .armed    (armed),
        .sig      (fair_sig),
        .seen_q   (fair_seen),
        .all_seen (fair_all)
      );
    end
  endgenerate

  assign violation = verdict(loop_hit, fair_all, live_all);
endmodule

// File: rtl/lasso_monitor_chk.sv
module lasso_monitor_chk
  import lasso_pkg::*;
#(
  parameter int STATE_W  = 4,
  parameter int N_LIVE   = 2,
  parameter int N_FAIR   = 2,
  parameter bit ONE_STEP = 1'b0
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     save,
  input logic [STATE_W-1:0]       state_cur,
  input logic [STATE_W-1:0]       state_nxt,
  input logic [lanes(N_LIVE)-1:0] live_sig,
  input logic                     saved_q,
  input logic [STATE_W-1:0]       shadow_q,
  input logic                     loop_hit,
  input logic [lanes(N_LIVE)-1:0] live_seen,
  input logic [lanes(N_FAIR)-1:0] fair_seen,
  input logic                     fair_all,
  input logic                     violation
);
  generate
    if (ONE_STEP) begin : g_os
      AST_OS_NEEDS_STEP: assert property (@(posedge clk)
        violation |-> (save && state_cur == state_nxt)); // R8
    end else begin : g_gen
      AST_SAVE_ARMS: assert property (@(posedge clk) disable iff (rst)
        save |=> saved_q); // R1
      AST_SAVED_STICKY: assert property (@(posedge clk) disable iff (rst)
        saved_q |=> saved_q); // R1
      AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
        save |=> (shadow_q == $past(state_cur))); // R2
      AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !save |=> $stable(shadow_q)); // R2
      AST_LOOP_NEEDS_SNAP: assert property (@(posedge clk) disable iff (rst)
        loop_hit |-> saved_q); // R3
      AST_IDLE_NO_SEEN: assert property (@(posedge clk) disable iff (rst)
        (!saved_q && !save) |=> (live_seen == '0 && fair_seen == '0)); // R4
      AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!saved_q && shadow_q == '0 && live_seen == '0 && fair_seen == '0)); // R7
      if (N_LIVE > 0) begin : g_live
        AST_SEEN_RESTART: assert property (@(posedge clk) disable iff (rst)
          save |=> (live_seen == $past(live_sig))); // R4
      end
    end
    if (N_LIVE == 0) begin : g_no_live
      AST_EMPTY_LIVE_QUIET: assert property (@(posedge clk)
        !violation); // R6
    end
  endgenerate

  AST_VIOL_NEEDS_LOOP: assert property (@(posedge clk) disable iff (rst)
    violation |-> loop_hit); // R5
  AST_VIOL_NEEDS_FAIR: assert property (@(posedge clk) disable iff (rst)
    violation |-> fair_all); // R5
endmodule

bind lasso_monitor lasso_monitor_chk #(
  .STATE_W (STATE_W),
  .N_LIVE  (N_LIVE),
  .N_FAIR  (N_FAIR),
  .ONE_STEP(ONE_STEP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .save      (save),
  .state_cur (state_cur),
  .state_nxt (state_nxt),
  .live_sig  (live_sig),
  .saved_q   (saved_q),
  .shadow_q  (shadow_q),
  .loop_hit  (loop_hit),
  .live_seen (live_seen),
  .fair_seen (fair_seen),
  .fair_all  (fair_all),
  .violation (violation)
);

// File: tb/lasso_monitor_test.sv
`timescale 1ns/1ps
module lasso_monitor_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       save = 1'b0;
  logic [3:0] st = '0, nx = '0;
  logic [1:0] lv = '0, fv = '0;
  logic       v_main, v_nl, v_nf, v_os;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Reference state, kept from the requirements.
  logic       m_saved = 1'b0;
  logic [3:0] m_shadow = '0;
  logic [1:0] m_live = '0, m_fair = '0;

  lasso_monitor #(.STATE_W(4), .N_LIVE(2), .N_FAIR(2), .ONE_STEP(1'b0)) uut (
    .clk(clk), .rst(rst), .save(save), .state_cur(st), .state_nxt(nx),
    .live_sig(lv), .fair_sig(fv), .violation(v_main));

  lasso_monitor #(.STATE_W(4), .N_LIVE(0), .N_FAIR(2), .ONE_STEP(1'b0)) uut_nl (
    .clk(clk), .rst(rst), .save(save), .state_cur(st), .state_nxt(nx),
    .live_sig(1'b0), .fair_sig(fv), .violation(v_nl));

  lasso_monitor #(.STATE_W(4), .N_LIVE(2), .N_FAIR(0), .ONE_STEP(1'b0)) uut_nf (
    .clk(clk), .rst(rst), .save(save), .state_cur(st), .state_nxt(nx),
    .live_sig(lv), .fair_sig(1'b0), .violation(v_nf));

  lasso_monitor #(.STATE_W(4), .N_LIVE(2), .N_FAIR(2), .ONE_STEP(1'b1)) uut_os (
    .clk(clk), .rst(rst), .save(save), .state_cur(st), .state_nxt(nx),
    .live_sig(lv), .fair_sig(fv), .violation(v_os));

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] s, input logic [3:0] n, input logic sv,
                      input logic [1:0] l, input logic [1:0] f, input logic r,
                      input string tag);
    logic loop, armed;
    @(negedge clk);
    st = s; nx = n; save = sv; lv = l; fv = f; rst = r;
    #1;
    loop = m_saved && (m_shadow == s);
    check(tag,       v_main, loop & (&m_fair) & ~(&m_live));
    check("R6 nolive", v_nl, 1'b0);
    check("R6 nofair", v_nf, loop & ~(&m_live));
    check("R8",      v_os,   sv & (s == n) & (&f) & ~(&l));
    @(posedge clk);
    if (r) begin
      m_saved = 1'b0; m_shadow = '0; m_live = '0; m_fair = '0;
    end else begin
      armed  = sv | m_saved;
      m_live = (sv ? 2'b00 : m_live) | (l & {2{armed}});
      m_fair = (sv ? 2'b00 : m_fair) | (f & {2{armed}});
      if (sv) m_shadow = s;
      m_saved = m_saved | sv;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    step(4'd0, 4'd1, 1'b0, 2'b00, 2'b00, 1'b1, "R7");
    step(4'd0, 4'd1, 1'b0, 2'b00, 2'b00, 1'b1, "R7");
    step(4'd0, 4'd1, 1'b0, 2'b00, 2'b11, 1'b0, "R7");
    // R1/R2/R3: snapshot at 5, loop closes, opens, closes again
    step(4'd5, 4'd5, 1'b1, 2'b00, 2'b11, 1'b0, "R2");
    step(4'd5, 4'd6, 1'b0, 2'b00, 2'b00, 1'b0, "R3");
    step(4'd6, 4'd5, 1'b0, 2'b00, 2'b00, 1'b0, "R3");
    step(4'd5, 4'd5, 1'b0, 2'b00, 2'b00, 1'b0, "R1");
    // R4: liveness lanes arrive one at a time
    step(4'd5, 4'd0, 1'b0, 2'b01, 2'b00, 1'b0, "R4");
    step(4'd5, 4'd0, 1'b0, 2'b10, 2'b00, 1'b0, "R4");
    step(4'd5, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0, "R4");
    // R9: new snapshot discards history
    step(4'd9, 4'd9, 1'b1, 2'b00, 2'b00, 1'b0, "R9");
    step(4'd9, 4'd2, 1'b0, 2'b00, 2'b00, 1'b0, "R9");
    step(4'd9, 4'd2, 1'b0, 2'b00, 2'b11, 1'b0, "R9");
    step(4'd9, 4'd2, 1'b0, 2'b00, 2'b00, 1'b0, "R9");
    // R7: reset during a closed lasso
    step(4'd9, 4'd2, 1'b0, 2'b00, 2'b00, 1'b1, "R7");
    step(4'd9, 4'd2, 1'b0, 2'b00, 2'b11, 1'b0, "R7");
    step(4'd0, 4'd9, 1'b0, 2'b00, 2'b00, 1'b0, "R7");
    // R8: one-step loops
    step(4'd3, 4'd3, 1'b1, 2'b01, 2'b11, 1'b0, "R8");
    step(4'd3, 4'd4, 1'b1, 2'b01, 2'b11, 1'b0, "R8");
    step(4'd3, 4'd3, 1'b1, 2'b11, 2'b11, 1'b0, "R8");
    // R5: broad sweep over a small state space
    for (int i = 0; i < 6000; i++) begin
      logic [3:0] s, n;
      s = 4'($urandom_range(0, 3));
      n = ($urandom_range(0, 3) == 0) ? s : 4'($urandom_range(0, 3));
      step(s, n, ($urandom_range(0, 7) == 0), 2'($urandom), 2'($urandom),
           ($urandom_range(0, 99) == 0), "R5");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule